// File: doc/BRIEF.md
# Segmented Effective Address Unit

This block turns the addressing fields of an instruction into a memory location. It takes the operand-address byte, up to two displacement bytes, an optional segment-override request and the current base, index and segment register values. From these it forms a 16-bit effective offset and picks one of four segment registers. It then builds a 20-bit physical address by shifting the chosen segment value left by four and adding the offset.

When the byte names a register operand instead of memory, the block reports that register's number and does not form an address. It also reports how many displacement bytes the instruction carries, so the fetch logic can step past them. All outputs are registered. They appear one clock after the inputs are presented.

Top module: `ea_unit`

## Requirements
- R1: When bits [7:6] of the operand-address byte are 11, reg_operand is 1 and reg_index equals bits [2:0] (word order AX=0, CX=1, DX=2, BX=3, SP=4, BP=5, SI=6, DI=7). In that case ea_offset and phys_addr are 0 and seg_sel is 3.
- R2: disp_len is 1 when bits [7:6] are 01 and 2 when they are 10. It is also 2 when bits [7:6] are 00 and bits [2:0] are 110. In every other case it is 0.
- R3: When bits [7:6] are 01, disp_lo is sign-extended to 16 bits before it is added.
- R4: When bits [7:6] are 10, the displacement is {disp_hi, disp_lo}.
- R5: Bits [2:0] of a memory form select the register sum, plus the displacement, as follows: 000 gives BX+SI, 001 gives BX+DI, 010 gives BP+SI, 011 gives BP+DI, 100 gives SI, 101 gives DI, 110 gives BP and 111 gives BX.
- R6: When bits [7:6] are 00 and bits [2:0] are 110, ea_offset is {disp_hi, disp_lo} and no register is added.
- R7: Any carry out of the 16-bit offset sum is discarded, so the offset wraps modulo 65536.
- R8: phys_addr equals (segment value × 16 + ea_offset) modulo 2^20. For example, segment 12A4h with offset 0022h gives 12A62h.
- R9: The segment codes are ES=0, CS=1, SS=2 and DS=3. Without an override, forms that add BP select SS (code 2) and all other memory forms select DS (code 3). The direct form of R6 selects DS.
- R10: When ovr_valid is 1 on a memory form, seg_sel equals ovr_code, even when the form adds BP.
- R11: While rst_n is low, every output is 0.
- R12: The outputs reflect the inputs of the previous rising clock edge. A change of the inputs between edges does not alter the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_byte | input | 8 | Operand-address byte (mod [7:6], aux [5:3], r/m [2:0]) |
| disp_lo | input | 8 | Low displacement byte |
| disp_hi | input | 8 | High displacement byte |
| ovr_valid | input | 1 | Segment override present |
| ovr_code | input | 2 | Override segment code |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| ea_offset | output | 16 | Effective offset |
| seg_sel | output | 2 | Selected segment code |
| phys_addr | output | 20 | Physical address |
| reg_operand | output | 1 | Operand is a register |
| reg_index | output | 3 | Register number for a register operand |
| disp_len | output | 2 | Displacement bytes, 0 to 2 |

## Verification
The assertions compare each output with the inputs of the previous edge. They rely on every input, including the segment registers, being stable across that edge, and they are armed only after one edge has passed outside reset. The bench changes inputs only on falling edges. Directed cases cover the sign bit of the short displacement, carry out of the 16-bit sum, carry past 1 MB, and an override on a BP form. Random operand-address bytes, displacements and register values then make up the bulk of the run.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int OFF_W     = 16;
  localparam int SEG_SHIFT = 4;
  localparam int PA_W      = OFF_W + SEG_SHIFT;
  localparam int NSEG      = 4;
  localparam int SUM_W     = OFF_W + 2;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_e;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_BYTE = 2'd1,
    DISP_WORD = 2'd2
  } disp_e;

  typedef struct packed {
    logic  is_reg;
    logic  add_bx;
    logic  add_bp;
    logic  add_si;
    logic  add_di;
    disp_e disp;
  } amode_t;

  function automatic logic [OFF_W-1:0] widen_disp(disp_e k, logic [7:0] lo, logic [7:0] hi);
    case (k)
      DISP_BYTE: return {{(OFF_W-8){lo[7]}}, lo};
      DISP_WORD: return {hi, lo};
      default:   return '0;
    endcase
  endfunction

  function automatic logic [PA_W-1:0] phys_of(logic [OFF_W-1:0] seg, logic [OFF_W-1:0] off);
    return {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off};
  endfunction
endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import ea_pkg::*;
(
  input  logic [7:0] addr_byte,
  output amode_t     mode
);
  logic [1:0] md;
  logic [2:0] rm;
  logic       direct;
  logic       aux_unused;

  assign md         = addr_byte[7:6];
  assign rm         = addr_byte[2:0];
  assign aux_unused = ^addr_byte[5:3];
  assign direct     = (md == 2'b00) && (rm == 3'b110);

  always_comb begin
    mode = '0;
    if (md == 2'b11) begin
      mode.is_reg = 1'b1;
    end else begin
      case (rm)
        3'd0: begin mode.add_bx = 1'b1; mode.add_si = 1'b1; end
        3'd1: begin mode.add_bx = 1'b1; mode.add_di = 1'b1; end
        3'd2: begin mode.add_bp = 1'b1; mode.add_si = 1'b1; end
        3'd3: begin mode.add_bp = 1'b1; mode.add_di = 1'b1; end
        3'd4: mode.add_si = 1'b1;
        3'd5: mode.add_di = 1'b1;
        3'd6: mode.add_bp = !direct;
        default: mode.add_bx = 1'b1;
      endcase
      case (md)
        2'b01:   mode.disp = DISP_BYTE;
        2'b10:   mode.disp = DISP_WORD;
        default: mode.disp = direct ? DISP_WORD : DISP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ea_offset_calc.sv
module ea_offset_calc
  import ea_pkg::*;
(
  input  logic             is_reg,
  input  logic             add_bx,
  input  logic             add_bp,
  input  logic             add_si,
  input  logic             add_di,
  input  disp_e            disp,
  input  logic [7:0]       disp_lo,
  input  logic [7:0]       disp_hi,
  input  logic [OFF_W-1:0] reg_bx,
  input  logic [OFF_W-1:0] reg_bp,
  input  logic [OFF_W-1:0] reg_si,
  input  logic [OFF_W-1:0] reg_di,
  output logic [OFF_W-1:0] offset,
  output logic             wrapped
);
  logic [OFF_W-1:0] base_v;
  logic [OFF_W-1:0] idx_v;
  logic [OFF_W-1:0] disp_v;
  logic [SUM_W-1:0] full_sum;

  always_comb begin
    base_v   = add_bx ? reg_bx : (add_bp ? reg_bp : '0);
    idx_v    = add_si ? reg_si : (add_di ? reg_di : '0);
    disp_v   = widen_disp(disp, disp_lo, disp_hi);
    full_sum = {2'b00, base_v} + {2'b00, idx_v} + {2'b00, disp_v};
    offset   = is_reg ? '0 : full_sum[OFF_W-1:0];
    wrapped  = !is_reg && (full_sum[SUM_W-1:OFF_W] != 2'b00);
  end
endmodule

// File: rtl/ea_seg_pick.sv
module ea_seg_pick
  import ea_pkg::*;
(
  input  logic             is_reg,
  input  logic             bp_used,
  input  logic             ovr_valid,
  input  logic [1:0]       ovr_code,
  input  logic [OFF_W-1:0] seg_bank [NSEG],
  output seg_e             sel,
  output logic [OFF_W-1:0] seg_val
);
  logic [NSEG-1:0]  hit;
  logic [OFF_W-1:0] masked [NSEG];

  always_comb begin
    if (is_reg)         sel = SEG_DS;
    else if (ovr_valid) sel = seg_e'(ovr_code);
    else if (bp_used)   sel = SEG_SS;
    else                sel = SEG_DS;
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign hit[g]    = (sel == seg_e'(g));
    assign masked[g] = {OFF_W{hit[g]}} & seg_bank[g];
  end

  always_comb begin
    seg_val = '0;
    for (int k = 0; k < NSEG; k++) seg_val = seg_val | masked[k];
  end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  addr_byte,
  input  logic [7:0]  disp_lo,
  input  logic [7:0]  disp_hi,
  input  logic        ovr_valid,
  input  logic [1:0]  ovr_code,
  input  logic [15:0] reg_bx,
  input  logic [15:0] reg_bp,
  input  logic [15:0] reg_si,
  input  logic [15:0] reg_di,
  input  logic [15:0] seg_es,
  input  logic [15:0] seg_cs,
  input  logic [15:0] seg_ss,
  input  logic [15:0] seg_ds,
  output logic [15:0] ea_offset,
  output logic [1:0]  seg_sel,
  output logic [19:0] phys_addr,
  output logic        reg_operand,
  output logic [2:0]  reg_index,
  output logic [1:0]  disp_len
);
  amode_t           mode;
  logic [OFF_W-1:0] off_c;
  logic             offset_wrap;
  logic             bp_implied;
  seg_e             sel_c;
  logic [OFF_W-1:0] seg_val_c;
  logic [PA_W-1:0]  pa_c;
  logic [OFF_W-1:0] seg_bank [NSEG];

  assign seg_bank[SEG_ES] = seg_es;
  assign seg_bank[SEG_CS] = seg_cs;
  assign seg_bank[SEG_SS] = seg_ss;
  assign seg_bank[SEG_DS] = seg_ds;
  assign bp_implied       = mode.add_bp;

  ea_mode_decode u_dec (
    .addr_byte (addr_byte),
    .mode      (mode)
  );

  ea_offset_calc u_off (
    .is_reg  (mode.is_reg),
    .add_bx  (mode.add_bx),
    .add_bp  (mode.add_bp),
    .add_si  (mode.add_si),
    .add_di  (mode.add_di),
    .disp    (mode.disp),
    .disp_lo (disp_lo),
    .disp_hi (disp_hi),
    .reg_bx  (reg_bx),
    .reg_bp  (reg_bp),
    .reg_si  (reg_si),
    .reg_di  (reg_di),
    .offset  (off_c),
    .wrapped (offset_wrap)
  );

  ea_seg_pick u_seg (
    .is_reg    (mode.is_reg),
    .bp_used   (bp_implied),
    .ovr_valid (ovr_valid),
    .ovr_code  (ovr_code),
    .seg_bank  (seg_bank),
    .sel       (sel_c),
    .seg_val   (seg_val_c)
  );

  assign pa_c = mode.is_reg ? '0 : phys_of(seg_val_c, off_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_offset   <= '0;
      seg_sel     <= '0;
      phys_addr   <= '0;
      reg_operand <= 1'b0;
      reg_index   <= '0;
      disp_len    <= '0;
    end else begin
      ea_offset   <= off_c;
      seg_sel     <= sel_c;
      phys_addr   <= pa_c;
      reg_operand <= mode.is_reg;
      reg_index   <= mode.is_reg ? addr_byte[2:0] : 3'd0;
      disp_len    <= mode.disp;
    end
  end
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk
  import ea_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  addr_byte,
  input logic [7:0]  disp_lo,
  input logic [7:0]  disp_hi,
  input logic        ovr_valid,
  input logic [1:0]  ovr_code,
  input logic [15:0] reg_si,
  input logic [15:0] seg_es,
  input logic [15:0] seg_cs,
  input logic [15:0] seg_ss,
  input logic [15:0] seg_ds,
  input logic        bp_implied,
  input logic [15:0] ea_offset,
  input logic [1:0]  seg_sel,
  input logic [19:0] phys_addr,
  input logic        reg_operand,
  input logic [2:0]  reg_index,
  input logic [1:0]  disp_len
);
  logic        prim_q;
  logic [15:0] es_q, cs_q, ss_q, ds_q;
  logic [15:0] picked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim_q <= 1'b0;
      es_q <= '0; cs_q <= '0; ss_q <= '0; ds_q <= '0;
    end else begin
      prim_q <= 1'b1;
      es_q <= seg_es; cs_q <= seg_cs; ss_q <= seg_ss; ds_q <= seg_ds;
    end
  end

  always_comb begin
    case (seg_sel)
      2'd0:    picked = es_q;
      2'd1:    picked = cs_q;
      2'd2:    picked = ss_q;
      default: picked = ds_q;
    endcase
  end

  assert_reg_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    prim_q && $past(addr_byte[7:6]) == 2'b11 |->
      reg_operand && reg_index == $past(addr_byte[2:0]) && ea_offset == 16'd0 && phys_addr == 20'd0);

  assert_disp_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prim_q && $past(addr_byte[7:6]) == 2'b01 |-> disp_len == 2'd1);

  assert_sign_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prim_q && $past(addr_byte[7:6]) == 2'b01 && $past(addr_byte[2:0]) == 3'b100 |->
      ea_offset == 16'($past(reg_si) + {{8{$past(disp_lo[7])}}, $past(disp_lo)}));

  assert_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prim_q && $past(addr_byte[7:6]) == 2'b00 && $past(addr_byte[2:0]) == 3'b110 |->
      ea_offset == {$past(disp_hi), $past(disp_lo)} && disp_len == 2'd2);

  assert_phys_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prim_q && !reg_operand |-> phys_addr == 20'({picked, 4'b0000} + {4'b0000, ea_offset}));

  assert_bp_stack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prim_q && !$past(ovr_valid) && $past(bp_implied) |-> seg_sel == 2'd2);

  assert_override_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prim_q && $past(ovr_valid) && $past(addr_byte[7:6]) != 2'b11 |-> seg_sel == $past(ovr_code));
endmodule

bind ea_unit ea_unit_chk u_ea_unit_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_byte   (addr_byte),
  .disp_lo     (disp_lo),
  .disp_hi     (disp_hi),
  .ovr_valid   (ovr_valid),
  .ovr_code    (ovr_code),
  .reg_si      (reg_si),
  .seg_es      (seg_es),
  .seg_cs      (seg_cs),
  .seg_ss      (seg_ss),
  .seg_ds      (seg_ds),
  .bp_implied  (bp_implied),
  .ea_offset   (ea_offset),
  .seg_sel     (seg_sel),
  .phys_addr   (phys_addr),
  .reg_operand (reg_operand),
  .reg_index   (reg_index),
  .disp_len    (disp_len)
);

// File: tb/ea_unit_bench.sv
module ea_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr_byte = '0, disp_lo = '0, disp_hi = '0;
  logic        ovr_valid = 1'b0;
  logic [1:0]  ovr_code = '0;
  logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
  logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
  logic [15:0] ea_offset;
  logic [1:0]  seg_sel;
  logic [19:0] phys_addr;
  logic        reg_operand;
  logic [2:0]  reg_index;
  logic [1:0]  disp_len;

  int n_chk = 0;
  int n_fail = 0;

  int e_off, e_seg, e_pa, e_reg, e_idx, e_len;
  string t_off, t_seg;

  always #5 clk = ~clk;

  ea_unit u_ea_unit (
    .clk(clk), .rst_n(rst_n), .addr_byte(addr_byte), .disp_lo(disp_lo), .disp_hi(disp_hi),
    .ovr_valid(ovr_valid), .ovr_code(ovr_code), .reg_bx(reg_bx), .reg_bp(reg_bp),
    .reg_si(reg_si), .reg_di(reg_di), .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss),
    .seg_ds(seg_ds), .ea_offset(ea_offset), .seg_sel(seg_sel), .phys_addr(phys_addr),
    .reg_operand(reg_operand), .reg_index(reg_index), .disp_len(disp_len)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference model: behavioural integer arithmetic over the current inputs.
  task automatic predict();
    int md, rm, d, raw, sv;
    bit direct, stack;
    md = int'(addr_byte) / 64;
    rm = int'(addr_byte) % 8;
    direct = (md == 0 && rm == 6);
    t_off = "R5";
    t_seg = ovr_valid ? "R10" : "R9";
    if (md == 3) begin
      e_reg = 1; e_idx = rm; e_off = 0; e_seg = 3; e_pa = 0; e_len = 0;
      t_seg = "R1";
      return;
    end
    e_reg = 0; e_idx = 0;
    if (md == 1) begin
      d = (disp_lo >= 128) ? int'(disp_lo) - 256 : int'(disp_lo);
      e_len = 1; t_off = "R3";
    end else if (md == 2) begin
      d = int'(disp_hi) * 256 + int'(disp_lo);
      e_len = 2; t_off = "R4";
    end else if (direct) begin
      d = int'(disp_hi) * 256 + int'(disp_lo);
      e_len = 2; t_off = "R6";
    end else begin
      d = 0; e_len = 0;
    end
    raw = d;
    stack = 0;
    case (rm)
      0: raw += int'(reg_bx) + int'(reg_si);
      1: raw += int'(reg_bx) + int'(reg_di);
      2: begin raw += int'(reg_bp) + int'(reg_si); stack = 1; end
      3: begin raw += int'(reg_bp) + int'(reg_di); stack = 1; end
      4: raw += int'(reg_si);
      5: raw += int'(reg_di);
      6: if (!direct) begin raw += int'(reg_bp); stack = 1; end
      default: raw += int'(reg_bx);
    endcase
    if (raw > 65535 || raw < 0) t_off = "R7";
    e_off = ((raw % 65536) + 65536) % 65536;
    e_seg = ovr_valid ? int'(ovr_code) : (stack ? 2 : 3);
    case (e_seg)
      0: sv = int'(seg_es);
      1: sv = int'(seg_cs);
      2: sv = int'(seg_ss);
      default: sv = int'(seg_ds);
    endcase
    e_pa = (sv * 16 + e_off) % 1048576;
  endtask

  task automatic compare_all();
    check(t_off, "offset", int'(ea_offset), e_off);
    check(t_seg, "segment", int'(seg_sel), e_seg);
    check("R8", "phys", int'(phys_addr), e_pa);
    check("R1", "reg flag", int'(reg_operand), e_reg);
    check("R1", "reg index", int'(reg_index), e_idx);
    check("R2", "disp len", int'(disp_len), e_len);
  endtask

  task automatic apply(logic [7:0] ab, logic [7:0] lo, logic [7:0] hi, logic ov, logic [1:0] oc,
                       logic [15:0] bx, logic [15:0] bp, logic [15:0] si, logic [15:0] di,
                       logic [15:0] es, logic [15:0] cs, logic [15:0] ss, logic [15:0] ds);
    addr_byte = ab; disp_lo = lo; disp_hi = hi; ovr_valid = ov; ovr_code = oc;
    reg_bx = bx; reg_bp = bp; reg_si = si; reg_di = di;
    seg_es = es; seg_cs = cs; seg_ss = ss; seg_ds = ds;
    predict();
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R11: outputs held at zero during reset even with live inputs
    apply(8'h46, 8'h22, 8'h00, 1'b0, 2'd0, 16'h1111, 16'h2222, 16'h3333, 16'h4444,
          16'h0100, 16'h0200, 16'h0300, 16'h12A4);
    repeat (3) @(negedge clk);
    check("R11", "reset offset", int'(ea_offset), 0);
    check("R11", "reset segment", int'(seg_sel), 0);
    check("R11", "reset phys", int'(phys_addr), 0);
    check("R11", "reset disp len", int'(disp_len), 0);
    rst_n = 1'b1;

    // R8/R6: direct form 12A4:0022 -> 12A62
    apply(8'h06, 8'h22, 8'h00, 1'b0, 2'd0, 16'h1111, 16'h2222, 16'h3333, 16'h4444,
          16'h0100, 16'h0200, 16'h0300, 16'h12A4);
    step();
    check("R8", "example phys", int'(phys_addr), 32'h12A62);
    // R12: input change between edges leaves outputs alone
    apply(8'hC5, 8'h00, 8'h00, 1'b0, 2'd0, 16'h0, 16'h0, 16'h0, 16'h0,
          16'h0, 16'h0, 16'h0, 16'h0);
    #1;
    check("R12", "held offset", int'(ea_offset), 32'h0022);
    check("R12", "held reg flag", int'(reg_operand), 0);
    step();
    // R7: BX+SI carry out dropped
    apply(8'h00, 8'h00, 8'h00, 1'b0, 2'd0, 16'hFFFF, 16'h0, 16'h0003, 16'h0,
          16'h0, 16'h0, 16'h0, 16'h0040);
    step();
    check("R7", "wrapped offset", int'(ea_offset), 2);
    // R3: negative byte displacement on SI
    apply(8'h44, 8'hF0, 8'h77, 1'b0, 2'd0, 16'h0, 16'h0, 16'h0010, 16'h0,
          16'h0, 16'h0, 16'h0, 16'h0);
    step();
    check("R3", "sign-extended sum", int'(ea_offset), 0);
    // R9: BP with byte displacement defaults to SS
    apply(8'h46, 8'h04, 8'h00, 1'b0, 2'd0, 16'h0, 16'h1000, 16'h0, 16'h0,
          16'h0AAA, 16'h0BBB, 16'h0CCC, 16'h0DDD);
    step();
    check("R9", "bp to stack", int'(seg_sel), 2);
    // R10: override ES on BP+DI
    apply(8'h83, 8'h00, 8'h01, 1'b1, 2'd0, 16'h0, 16'h1000, 16'h0, 16'h0020,
          16'h0AAA, 16'h0BBB, 16'h0CCC, 16'h0DDD);
    step();
    check("R10", "override on bp", int'(seg_sel), 0);
    // R8: physical address wraps past 1 MB
    apply(8'h07, 8'h00, 8'h00, 1'b0, 2'd0, 16'h0020, 16'h0, 16'h0, 16'h0,
          16'h0, 16'h0, 16'h0, 16'hFFFF);
    step();
    check("R8", "phys wrap", int'(phys_addr), 32'h00010);
    // R1: register operand, override ignored
    apply(8'hFE, 8'h55, 8'h66, 1'b1, 2'd1, 16'h1, 16'h2, 16'h3, 16'h4,
          16'h5, 16'h6, 16'h7, 16'h8);
    step();
    check("R1", "reg number", int'(reg_index), 6);

    for (int i = 0; i < 600; i++) begin
      apply(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom % 3 == 0), 2'($urandom),
            16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
            16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule